// File: doc/BRIEF.md
# Privileged Register Access Controller

This block serves the two instructions that move a value to or from the processor's internal register space. Each request carries the current privilege mode, an opcode, a register number, a source value and the incoming condition codes N, Z, V and C. The controller checks the request and then performs the transfer. It first checks the privilege mode. It then checks that the register number exists and that the register permits the requested direction. A request that passes all checks performs the read or the write. The result, the fault flags and the updated condition codes appear on registered outputs one clock after the request.

The register space holds the following:
- the four per-mode stack pointers and the interrupt stack pointer;
- three pairs of base and length registers for memory management;
- a 5-bit interrupt priority level;
- a pending software interrupt summary, with a write-only request port that sets one bit of it;
- a memory mapping enable bit;
- a constant machine identifier.

A write to either of the two translation buffer invalidate numbers stores nothing. It only produces a one-cycle strobe for the memory management logic.

Top module: `priv_reg_unit`

## Requirements
- R1: A request with a recognised opcode (0xDA write, 0xDB read) whose mode is not kernel (mode code 0) raises only the privilege fault, whatever the register number.
- R2: In kernel mode, a register number outside the set {0-4, 8-13, 18, 20, 21, 56, 57, 58, 62} raises only the operand fault.
- R3: In kernel mode, reading a write-only number (20, 57, 58) or writing the read-only number 62 raises only the operand fault.
- R4: After a successful transfer of value X (the written value, or the value read), ccOut = {N = X[31], Z = (X == 0), V = 0, C = ccIn[0]}, with bit order {N,Z,V,C} from bit 3 down to bit 0.
- R5: A faulting request changes no register, returns rdData 0 and sets ccOut equal to that request's ccIn.
- R6: Numbers 0-4 and 8-13 store full 32-bit values. respValid and the results appear one clock after the request. A read issued in the clock after a write returns the written value.
- R7: Register 18 keeps bits 4:0 of a write and reads back zero-extended.
- R8: Register 21 keeps bits 15:1 of a write, and its bit 0 always reads 0. Writing register 20 with level L = data[3:0] sets bit L of register 21 when L is nonzero. Writing register 20 with level 0 changes nothing.
- R9: A successful write to 57 pulses tbInvAll and a successful write to 58 pulses tbInvSingle, each for the single response cycle.
- R10: After reset all outputs are 0. Registers 18, 21 and 56 read 0, and register 62 reads the SID_VALUE parameter.
- R11: A request with any other opcode gives no response and changes no state.
- R12: Register 56 keeps only bit 0 of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 8 | Opcode: 0xDA write, 0xDB read |
| curMode | input | 2 | Privilege mode, 0 is kernel |
| regNum | input | 6 | Register number |
| wrData | input | 32 | Source value for a write |
| ccIn | input | 4 | Incoming {N,Z,V,C} |
| respValid | output | 1 | Response for the previous cycle's request |
| rdData | output | 32 | Value read, 0 unless a successful read |
| ccOut | output | 4 | Resulting {N,Z,V,C} |
| faultPriv | output | 1 | Privilege (reserved instruction) fault |
| faultOperand | output | 1 | Operand (nonexistent or wrong direction) fault |
| tbInvAll | output | 1 | Invalidate-all strobe |
| tbInvSingle | output | 1 | Invalidate-single strobe |

## Verification
The bench writes a register and reads it back. Because of this, a corrupted stored value or a wrong index mapping shows up in rdData and in the N and Z bits of ccOut on the response one clock after the read. A wrong permission decode surfaces at once, on the response to the same request, as a missing or extra fault flag. A transfer that wrongly went ahead after a fault is caught by the next kernel read of that register. A slipped bit position in the level, summary or enable registers shows up as a changed read value on the first read after the write.

// File: rtl/priv_reg_pkg.sv
package priv_reg_pkg;
  localparam logic [7:0] OP_WRITE = 8'hDA;
  localparam logic [7:0] OP_READ  = 8'hDB;

  localparam int SP_CNT   = 5;   // numbers 0..4
  localparam int BL_BASE  = 8;   // numbers 8..13
  localparam int BL_CNT   = 6;
  localparam int GEN_CNT  = SP_CNT + BL_CNT;
  localparam int GEN_IDXW = $clog2(GEN_CNT);

  localparam int RN_LEVEL   = 18;
  localparam int RN_SWREQ   = 20;
  localparam int RN_SWSUM   = 21;
  localparam int RN_MAPON   = 56;
  localparam int RN_INVALL  = 57;
  localparam int RN_INVONE  = 58;
  localparam int RN_MACHID  = 62;

  typedef struct packed {
    logic                genHit;
    logic [GEN_IDXW-1:0] genIdx;
    logic                wrGen;
    logic                wrLevel;
    logic                wrSum;
    logic                setSw;
    logic                wrMap;
  } dpStrobe_t;
endpackage

// File: rtl/priv_reg_dp.sv
module priv_reg_dp
  import priv_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_W = 6,
  parameter logic [DATA_W-1:0] SID_VALUE = 32'h0A00_0001,
  parameter int LEVEL_W = 5,
  parameter int SUM_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [NUM_W-1:0]  regNum,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdValue
);
  localparam int LVL_W = $clog2(SUM_W);

  logic [DATA_W-1:0]  genReg [GEN_CNT];
  logic [LEVEL_W-1:0] levelReg;
  logic [SUM_W-1:0]   sumReg;
  logic               mapReg;
  logic [LVL_W-1:0]   swLevel;

  assign swLevel = wrData[LVL_W-1:0];

  for (genvar g = 0; g < GEN_CNT; g++) begin : gen_store
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) genReg[g] <= '0;
      else if (strobe.wrGen && strobe.genIdx == GEN_IDXW'(g)) genReg[g] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelReg <= '0;
      sumReg   <= '0;
      mapReg   <= 1'b0;
    end else begin
      if (strobe.wrLevel) levelReg <= wrData[LEVEL_W-1:0];
      if (strobe.wrSum) sumReg <= {wrData[SUM_W-1:1], 1'b0};
      else if (strobe.setSw && swLevel != '0) sumReg[swLevel] <= 1'b1;
      if (strobe.wrMap) mapReg <= wrData[0];
    end
  end

  always_comb begin
    rdValue = '0;
    if (strobe.genHit) rdValue = genReg[strobe.genIdx];
    else begin
      case (regNum)
        NUM_W'(RN_LEVEL):  rdValue = DATA_W'(levelReg);
        NUM_W'(RN_SWSUM):  rdValue = DATA_W'(sumReg);
        NUM_W'(RN_MAPON):  rdValue = DATA_W'(mapReg);
        NUM_W'(RN_MACHID): rdValue = SID_VALUE;
        default:           rdValue = '0;
      endcase
    end
  end

  // R7: the level only moves on its own write strobe
  p_level_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrLevel |=> $stable(levelReg));
  // R8: summary bit 0 never set
  p_sum_bit0_r8: assert property (@(posedge clk) disable iff (!rstN)
    sumReg[0] == 1'b0);
  // R12: enable holds without its strobe
  p_map_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrMap |=> $stable(mapReg));
endmodule

// File: rtl/priv_reg_ctrl.sv
module priv_reg_ctrl
  import priv_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        reqOp,
  input  logic [1:0]        curMode,
  input  logic [NUM_W-1:0]  regNum,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        ccIn,
  input  logic [DATA_W-1:0] rdValue,
  output dpStrobe_t         strobe,
  output logic              respValid,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        ccOut,
  output logic              faultPriv,
  output logic              faultOperand,
  output logic              tbInvAll,
  output logic              tbInvSingle
);
  logic isWr, isRd, isOp, kernel, isSp, isBl, rdOk, wrOk, allowed, good;
  logic [NUM_W-1:0]  genIdxFull;
  logic [DATA_W-1:0] xferVal;
  logic [3:0]        newCc;

  assign isWr   = reqValid && reqOp == OP_WRITE;
  assign isRd   = reqValid && reqOp == OP_READ;
  assign isOp   = isWr || isRd;
  assign kernel = curMode == 2'd0;
  assign isSp   = regNum < NUM_W'(SP_CNT);
  assign isBl   = regNum >= NUM_W'(BL_BASE) && regNum < NUM_W'(BL_BASE + BL_CNT);

  always_comb begin
    rdOk = isSp || isBl;
    wrOk = isSp || isBl;
    case (regNum)
      NUM_W'(RN_LEVEL), NUM_W'(RN_SWSUM), NUM_W'(RN_MAPON): begin
        rdOk = 1'b1; wrOk = 1'b1;
      end
      NUM_W'(RN_SWREQ), NUM_W'(RN_INVALL), NUM_W'(RN_INVONE): wrOk = 1'b1;
      NUM_W'(RN_MACHID): rdOk = 1'b1;
      default: ;
    endcase
  end

  assign allowed    = isWr ? wrOk : rdOk;
  assign good       = isOp && kernel && allowed;
  assign genIdxFull = isSp ? regNum : regNum - NUM_W'(BL_BASE - SP_CNT);

  always_comb begin
    strobe         = '0;
    strobe.genHit  = isSp || isBl;
    strobe.genIdx  = genIdxFull[GEN_IDXW-1:0];
    strobe.wrGen   = good && isWr && (isSp || isBl);
    strobe.wrLevel = good && isWr && regNum == NUM_W'(RN_LEVEL);
    strobe.wrSum   = good && isWr && regNum == NUM_W'(RN_SWSUM);
    strobe.setSw   = good && isWr && regNum == NUM_W'(RN_SWREQ);
    strobe.wrMap   = good && isWr && regNum == NUM_W'(RN_MAPON);
  end

  assign xferVal = isWr ? wrData : rdValue;
  assign newCc   = {xferVal[DATA_W-1], xferVal == '0, 1'b0, ccIn[0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      rdData       <= '0;
      ccOut        <= '0;
      faultPriv    <= 1'b0;
      faultOperand <= 1'b0;
      tbInvAll     <= 1'b0;
      tbInvSingle  <= 1'b0;
    end else begin
      respValid    <= isOp;
      faultPriv    <= isOp && !kernel;
      faultOperand <= isOp && kernel && !allowed;
      rdData       <= (good && isRd) ? rdValue : '0;
      if (isOp) ccOut <= good ? newCc : ccIn;
      tbInvAll     <= good && isWr && regNum == NUM_W'(RN_INVALL);
      tbInvSingle  <= good && isWr && regNum == NUM_W'(RN_INVONE);
    end
  end

  // R1: outside kernel mode only the privilege fault follows
  p_mode_fault_r1: assert property (@(posedge clk) disable iff (!rstN)
    (isOp && !kernel) |=> (respValid && faultPriv && !faultOperand));
  // R2: the two faults never coincide
  p_fault_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(faultPriv && faultOperand));
  // R4: V is clear after any successful transfer
  p_v_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !faultPriv && !faultOperand) |-> !ccOut[1]);
  // R5: a privilege fault passes the incoming codes through
  p_cc_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isOp && !kernel) |=> (ccOut == $past(ccIn) && rdData == '0));
  // R9: strobes only on a successful response
  p_strobe_ok_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tbInvAll || tbInvSingle) |-> (respValid && !faultPriv && !faultOperand));
  // R11: unknown opcodes give no response
  p_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isOp) |=> !respValid);
endmodule

// File: rtl/priv_reg_unit.sv
module priv_reg_unit
  import priv_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_W = 6,
  parameter logic [DATA_W-1:0] SID_VALUE = 32'h0A00_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        reqOp,
  input  logic [1:0]        curMode,
  input  logic [NUM_W-1:0]  regNum,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        ccIn,
  output logic              respValid,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        ccOut,
  output logic              faultPriv,
  output logic              faultOperand,
  output logic              tbInvAll,
  output logic              tbInvSingle
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] rdValue;

  priv_reg_ctrl #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .curMode(curMode), .regNum(regNum), .wrData(wrData), .ccIn(ccIn),
    .rdValue(rdValue), .strobe(strobe), .respValid(respValid),
    .rdData(rdData), .ccOut(ccOut), .faultPriv(faultPriv),
    .faultOperand(faultOperand), .tbInvAll(tbInvAll), .tbInvSingle(tbInvSingle)
  );

  priv_reg_dp #(.DATA_W(DATA_W), .NUM_W(NUM_W), .SID_VALUE(SID_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regNum(regNum),
    .wrData(wrData), .rdValue(rdValue)
  );
endmodule

// File: tb/tb_priv_reg_unit.sv
module tb_priv_reg_unit;
  localparam logic [31:0] SID = 32'h0A00_0001;
  localparam logic [7:0] WR = 8'hDA, RD = 8'hDB;

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic [7:0] reqOp = '0;
  logic [1:0] curMode = '0;
  logic [5:0] regNum = '0;
  logic [31:0] wrData = '0;
  logic [3:0] ccIn = '0;
  logic respValid, faultPriv, faultOperand, tbInvAll, tbInvSingle;
  logic [31:0] rdData;
  logic [3:0] ccOut;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  priv_reg_unit #(.SID_VALUE(SID)) dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge (one register stage)
  task automatic req(logic [7:0] op, logic [1:0] md, logic [5:0] num,
                     logic [31:0] d, logic [3:0] cc);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; curMode = md; regNum = num; wrData = d; ccIn = cc;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectOk(string tag, logic [31:0] rd, logic [3:0] cc);
    chk({tag, " resp"}, {29'd0, respValid, faultPriv, faultOperand}, 32'b100);
    chk({tag, " rdData"}, rdData, rd);
    chk({tag, " cc"}, 32'(ccOut), 32'(cc));
  endtask

  task automatic expectFault(string tag, bit priv, logic [3:0] cc);
    chk({tag, " faults"}, {29'd0, respValid, faultPriv, faultOperand},
        {29'd0, 1'b1, priv, !priv});
    chk({tag, " cc"}, 32'(ccOut), 32'(cc));
    chk({tag, " rdData"}, rdData, 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 reset outputs", {rdData[27:0], ccOut, respValid, faultPriv,
        faultOperand, tbInvAll, tbInvSingle}, 0);
    req(RD, 0, 18, 0, 4'b0001); expectOk("R10 level reset", 0, 4'b0101);
    req(RD, 0, 21, 0, 4'b0000); expectOk("R10 summary reset", 0, 4'b0100);
    req(RD, 0, 56, 0, 4'b0000); expectOk("R10 enable reset", 0, 4'b0100);
    req(RD, 0, 62, 0, 4'b0011); expectOk("R10 id R4", SID, 4'b0001);
  endtask

  task automatic t_roundtrip();
    req(WR, 0, 3, 32'h8000_0010, 4'b0000); expectOk("R6 write sp3 R4", 0, 4'b1000);
    req(RD, 0, 3, 0, 4'b1111); expectOk("R6 read sp3 R4", 32'h8000_0010, 4'b1001);
    req(WR, 0, 13, 0, 4'b0010); expectOk("R6 write bl13 R4 V clear", 0, 4'b0100);
    req(RD, 0, 13, 0, 4'b0000); expectOk("R6 read bl13", 0, 4'b0100);
    req(WR, 0, 8, 32'h0000_1234, 4'b0000); expectOk("R6 write bl8", 0, 4'b0000);
    req(RD, 0, 8, 0, 4'b0000); expectOk("R6 read bl8", 32'h1234, 4'b0000);
    req(RD, 0, 0, 0, 4'b0000); expectOk("R6 sp0 untouched", 0, 4'b0100);
    req(WR, 0, 4, 32'h0000_0444, 4'b0000);
    req(RD, 0, 4, 0, 4'b0000); expectOk("R6 read sp4", 32'h444, 4'b0000);
    req(RD, 0, 3, 0, 4'b0000); expectOk("R6 sp3 kept", 32'h8000_0010, 4'b1000);
  endtask

  task automatic t_level_sum_map();
    req(WR, 0, 18, 32'hFFFF_FFFF, 4'b0000); expectOk("R7 write level", 0, 4'b1000);
    req(RD, 0, 18, 0, 4'b0000); expectOk("R7 read level", 32'h1F, 4'b0000);
    req(WR, 0, 21, 32'hFFFF_FFFF, 4'b0000);
    req(RD, 0, 21, 0, 4'b0000); expectOk("R8 summary mask", 32'hFFFE, 4'b0000);
    req(WR, 0, 21, 0, 4'b0000);
    req(WR, 0, 20, 32'h5, 4'b0000); expectOk("R8 request write", 0, 4'b0000);
    req(RD, 0, 21, 0, 4'b0000); expectOk("R8 level 5 set", 32'h20, 4'b0000);
    req(WR, 0, 20, 32'h10, 4'b0000);
    req(RD, 0, 21, 0, 4'b0000); expectOk("R8 level 0 no change", 32'h20, 4'b0000);
    req(WR, 0, 56, 32'h3, 4'b0000);
    req(RD, 0, 56, 0, 4'b0000); expectOk("R12 enable bit0", 32'h1, 4'b0000);
    req(WR, 0, 56, 32'h2, 4'b0000);
    req(RD, 0, 56, 0, 4'b0000); expectOk("R12 enable cleared", 32'h0, 4'b0100);
  endtask

  task automatic t_strobes();
    req(WR, 0, 57, 32'h1, 4'b0000);
    chk("R9 inv all strobes", {30'd0, tbInvAll, tbInvSingle}, 32'b10);
    @(negedge clk);
    chk("R9 inv all one cycle", {30'd0, tbInvAll, tbInvSingle}, 0);
    req(WR, 0, 58, 32'h1, 4'b0000);
    chk("R9 inv one strobes", {30'd0, tbInvAll, tbInvSingle}, 32'b01);
    @(negedge clk);
    chk("R9 inv one one cycle", {30'd0, tbInvAll, tbInvSingle}, 0);
  endtask

  task automatic t_faults();
    req(WR, 3, 0, 32'hDEAD_BEEF, 4'b1010); expectFault("R1 user write", 1, 4'b1010);
    req(RD, 0, 0, 0, 4'b0000); expectOk("R5 sp0 unchanged", 0, 4'b0100);
    req(RD, 1, 5, 0, 4'b0101); expectFault("R1 nonexistent nonkernel", 1, 4'b0101);
    req(WR, 2, 57, 0, 4'b0000); expectFault("R1 inv blocked", 1, 4'b0000);
    chk("R5 no strobe on fault", {30'd0, tbInvAll, tbInvSingle}, 0);
    req(RD, 0, 5, 0, 4'b1111); expectFault("R2 read 5", 0, 4'b1111);
    req(WR, 0, 63, 32'h1, 4'b0110); expectFault("R2 write 63", 0, 4'b0110);
    req(RD, 0, 20, 0, 4'b0000); expectFault("R3 read 20", 0, 4'b0000);
    req(RD, 0, 57, 0, 4'b0001); expectFault("R3 read 57", 0, 4'b0001);
    req(WR, 0, 62, 32'h0, 4'b1000); expectFault("R3 write 62", 0, 4'b1000);
    req(RD, 0, 62, 0, 4'b0000); expectOk("R5 id intact", SID, 4'b0000);
    req(WR, 1, 18, 32'h7, 4'b0000);
    req(RD, 0, 18, 0, 4'b0000); expectOk("R5 level intact", 32'h1F, 4'b0000);
  endtask

  task automatic t_ignore();
    req(8'h00, 0, 1, 32'h7777_0000, 4'b0000);
    chk("R11 no response", {31'd0, respValid}, 0);
    req(8'hDC, 0, 1, 32'h7777_0000, 4'b0000);
    chk("R11 no response 2", {31'd0, respValid}, 0);
    req(RD, 0, 1, 0, 4'b0000); expectOk("R11 sp1 unchanged", 0, 4'b0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_roundtrip();
    t_level_sum_map();
    t_strobes();
    t_faults();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule